// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands over a fixed run of clock cycles and uses a single adder that is as wide as one operand. One product register, twice the operand width, does two jobs. At launch its upper half is cleared and its lower half takes the multiplier. On each step the least significant bit of that register decides whether the stored multiplicand is added into the upper half. The register then shifts right by one place, and the adder's carry-out enters at the top.

A client raises `start` for one cycle while the block is idle and drives both operands in that same cycle. `busy` stays high for exactly `WIDTH` cycles. `done` then pulses for one cycle, and `product` keeps the full-width result until the next accepted launch. Signed products can be built around the block by taking operand magnitudes and negating the result outside it.

Top module: `shmul_seq_top`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` seen high at a clock edge while `busy` is 0 and `done` is 0 launches a run: after that edge `busy` is 1 and `done` is 0.
- R3: On completion, `product` equals the unsigned product of the multiplicand and multiplier that were sampled at the launch edge, over the full 2*WIDTH bits.
- R4: `busy` stays 1 for exactly WIDTH cycles after the launch edge. At the WIDTH-th edge after launch, `busy` falls and `done` goes to 1 for exactly one cycle.
- R5: A `start` pulse during a run, together with any change on the operand inputs, does not alter that run's result or its completion timing.
- R6: The carry-out of each addition is kept as the new top bit, so all-ones operands give 2^(2*WIDTH) - 2^(WIDTH+1) + 1 (for WIDTH=32 this is 0xFFFFFFFE00000001).
- R7: While the block is idle and no start is applied, `product` holds its value whatever the operand inputs do.
- R8: A zero multiplicand or a zero multiplier gives a product of zero. A multiplicand or multiplier of 1 returns the other operand unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch request, acted on only while idle |
| multiplicand | input | WIDTH | Unsigned multiplicand, sampled at launch |
| multiplier | input | WIDTH | Unsigned multiplier, sampled at launch |
| busy | output | 1 | High while the shift-add steps run |
| done | output | 1 | One-cycle pulse when the result is ready |
| product | output | 2*WIDTH | Unsigned product register |

## Verification
Counting the launch edge as edge 0, `busy` is due high after edge 0. It must remain high after edges 1 through WIDTH-1. After edge WIDTH, `done`, the falling `busy` and the final `product` are all due together, and `done` must be low again after edge WIDTH+1. The bench drives inputs on falling edges and samples every output on the falling edge that follows each of those rising edges, so each check lands in the exact cycle the requirement names. A start pulse injected mid-run still has to produce completion at edge WIDTH with the original operands' product.

// File: rtl/shmul_pkg.sv
// Package: shared types for the sequential shift-add multiplier.
// Assumes: only the sequencing state is shared between modules.
package shmul_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } shmul_state_t;

endpackage

// File: rtl/shmul_add.sv
// Module: shmul_add
// Adds the gated multiplicand to the upper half of the product.
// Assumes: both inputs are unsigned and the carry-out sits at bit WIDTH.
module shmul_add #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] upper,
    input  logic [WIDTH-1:0] addend,
    input  logic             enable,
    output logic [WIDTH:0]   sum
);

    // Conditional add; passes upper through when not enabled.
    always_comb begin
        if (enable) sum = {1'b0, upper} + {1'b0, addend};
        else        sum = {1'b0, upper};
    end

endmodule

// File: rtl/shmul_ctrl.sv
// Module: shmul_ctrl
// Sequencer: accepts a launch while idle, counts WIDTH steps, pulses done.
// Assumes: one shift-add step per clock; start during a run is ignored.
module shmul_ctrl
    import shmul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);

    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    shmul_state_t     state;
    logic [CW-1:0]    step_cnt;

    // Decode launch and step strobes from the current state.
    always_comb begin
        load = (state == ST_IDLE) && start;
        step = (state == ST_RUN);
        busy = (state == ST_RUN);
    end

    // State, step counter and done pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            step_cnt <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_RUN;
                        step_cnt <= '0;
                    end
                end
                ST_RUN: begin
                    if (step_cnt == LAST) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                    step_cnt <= step_cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/shmul_datapath.sv
// Module: shmul_datapath
// Holds the multiplicand and the double-width product register. The low
// half carries the multiplier, which is consumed one bit per step.
// Assumes: load and step are never high together.
module shmul_datapath #(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   mcand_in,
    input  logic [WIDTH-1:0]   mplier_in,
    output logic [2*WIDTH-1:0] prod
);

    localparam int PW = 2 * WIDTH;

    logic [WIDTH-1:0] mcand_q;
    logic [WIDTH:0]   sum;

    shmul_add #(.WIDTH(WIDTH)) u_add (
        .upper  (prod[PW-1:WIDTH]),
        .addend (mcand_q),
        .enable (prod[0]),
        .sum    (sum)
    );

    // Multiplicand capture at launch; it is never shifted.
    always_ff @(posedge clk) begin
        if (!rst_n)    mcand_q <= '0;
        else if (load) mcand_q <= mcand_in;
    end

    // Product register: load the multiplier, or add and shift right with carry-in.
    always_ff @(posedge clk) begin
        if (!rst_n)      prod <= '0;
        else if (load)   prod <= {{WIDTH{1'b0}}, mplier_in};
        else if (step)   prod <= {sum, prod[WIDTH-1:1]};
    end

endmodule

// File: rtl/shmul_seq_top.sv
// Module: shmul_seq_top
// Unsigned WIDTH x WIDTH multiplier built from a shift-add loop.
// Assumes: operands are valid in the cycle start is sampled while idle.
module shmul_seq_top #(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   multiplicand,
    input  logic [WIDTH-1:0]   multiplier,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);

    logic load;
    logic step;

    shmul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    shmul_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .mcand_in  (multiplicand),
        .mplier_in (multiplier),
        .prod      (product)
    );

endmodule

// File: rtl/shmul_seq_checker.sv
// Module: shmul_seq_checker
// Protocol checks on the multiplier's ports, bound to shmul_seq_top.
// Assumes: reset is synchronous and active low.
module shmul_seq_checker #(
    parameter int WIDTH = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic [2*WIDTH-1:0] product
);

    localparam int RW = $clog2(WIDTH + 1) + 1;

    logic [RW-1:0] run_len;

    // Count cycles spent busy; cleared whenever idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) run_len <= '0;
        else                 run_len <= run_len + 1'b1;
    end

    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> (busy && !done));              // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                             // R4
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                             // R4
    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == RW'(WIDTH)));                           // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));                     // R7

endmodule

bind shmul_seq_top shmul_seq_checker #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/tb_shmul_seq_top.sv
module tb_shmul_seq_top;

    localparam int W = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [W-1:0]   multiplicand = '0;
    logic [W-1:0]   multiplier = '0;
    logic           busy;
    logic           done;
    logic [2*W-1:0] product;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    shmul_seq_top #(.WIDTH(W)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .multiplicand (multiplicand),
        .multiplier   (multiplier),
        .busy         (busy),
        .done         (done),
        .product      (product)
    );

    always #4 clk = ~clk;

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [2*W-1:0] wa, wb;
        wa = {{W{1'b0}}, a};
        wb = {{W{1'b0}}, b};
        return wa * wb;
    endfunction

    task automatic check(input bit ok, input string req, input logic [2*W-1:0] act,
                         input logic [2*W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One full multiplication; optionally pokes start and operands mid-run.
    task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
        logic [2*W-1:0] exp;
        bit run_ok;
        exp = ref_mul(a, b);
        @(negedge clk);
        multiplicand = a;
        multiplier   = b;
        start        = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !done, "R2 launch", {62'b0, busy, done}, 64'h2);
        run_ok = 1'b1;
        for (int i = 1; i < W; i++) begin
            @(negedge clk);
            if (!busy || done) run_ok = 1'b0;
            if (poke && i == 10) begin
                start        = 1'b1;
                multiplicand = ~a;
                multiplier   = b ^ 32'h5a5a_a5a5;
            end else begin
                start = 1'b0;
            end
        end
        check(run_ok, "R4 busy window", {63'b0, run_ok}, 64'h1);
        @(negedge clk);
        check(done && !busy, "R4 done at edge W", {62'b0, busy, done}, 64'h1);
        check(product == exp, poke ? "R5 R3 product" : "R3 product", product, exp);
        @(negedge clk);
        check(!done, "R4 done pulse one cycle", {63'b0, done}, 64'h0);
        check(product == exp, "R7 product held", product, exp);
    endtask

    initial begin
        logic [2*W-1:0] held;
        void'($urandom(32'h1357_2468));
        repeat (3) @(negedge clk);
        check(!busy && !done && product == '0, "R1 reset state", product, 64'h0);
        rst_n = 1'b1;

        run_mul(32'd7, 32'd6, 1'b0);
        run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        check(product == 64'hFFFF_FFFE_0000_0001, "R6 carry kept", product,
              64'hFFFF_FFFE_0000_0001);
        run_mul(32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
        run_mul(32'd0, 32'hDEAD_BEEF, 1'b0);
        check(product == '0, "R8 zero multiplicand", product, 64'h0);
        run_mul(32'h1234_5678, 32'd0, 1'b0);
        check(product == '0, "R8 zero multiplier", product, 64'h0);
        run_mul(32'd1, 32'hCAFE_F00D, 1'b0);
        check(product == 64'h0000_0000_CAFE_F00D, "R8 unit multiplicand", product,
              64'hCAFE_F00D);
        run_mul(32'h0BAD_CAFE, 32'd1, 1'b0);
        check(product == 64'h0000_0000_0BAD_CAFE, "R8 unit multiplier", product,
              64'h0BAD_CAFE);

        // R5: start and operand changes during a run are ignored.
        run_mul(32'hA5A5_1234, 32'h0F0F_F0F0, 1'b1);
        run_mul(32'hFFFF_FFFF, 32'h8000_0001, 1'b1);

        // R7: idle with moving operands keeps product.
        held = product;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            multiplicand = $urandom;
            multiplier   = $urandom;
        end
        @(negedge clk);
        check(product == held && !busy, "R7 idle hold", product, held);

        for (int n = 0; n < 40; n++) begin
            logic [W-1:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (n % 5 == 0) ra = ra | 32'h8000_0000;
            run_mul(ra, rb, n % 7 == 3);
        end

        // R1: reset mid-run returns the idle state.
        @(negedge clk);
        multiplicand = 32'd9;
        multiplier   = 32'd9;
        start        = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !done && product == '0, "R1 reset mid-run", product, 64'h0);
        rst_n = 1'b1;
        run_mul(32'd3, 32'd5, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule